// File: doc/BRIEF.md
# Trimmed-Mean Sensor Sample Filter

This block smooths raw readings from up to four temperature sensing points. Samples arrive one at a time on a shared stream, and each is tagged with the index of the point it came from. Each point keeps its own window and follows its own 3-bit mode, taken from a 12-bit control word. A mode either passes every sample straight through or gathers a fixed number of samples. For the larger windows, the block then drops the single largest and the single smallest sample and averages the rest with a right shift.

The filter keeps a running sum, minimum and maximum for each point as samples come in, so it needs no sample storage and no divider. When the last sample of a window arrives, the block computes the result and presents it on the next cycle as a one-cycle strobe, together with the point index.

Top module: `trim_filter`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid` is low; every point starts with an empty window.
- R2: In mode 000, each sample accepted for that point produces `out_value` equal to the sample itself.
- R3: In mode 001, every second sample of a point produces floor((a+b)/2) of the two samples in that window.
- R4: In mode 010, every fourth sample produces floor((sum − max − min)/2) over the four samples.
- R5: In mode 011, every sixth sample produces floor((sum − max − min)/4) over the six samples.
- R6: In mode 100, every tenth sample produces floor((sum − max − min)/8) over the ten samples.
- R7: In mode 101, every eighteenth sample produces floor((sum − max − min)/16) over the eighteen samples, with no overflow even when all samples are 0xFFFF. Only one copy of a repeated extreme value is removed.
- R8: The codes 110 and 111 behave exactly like mode 000.
- R9: Point p takes its mode from `mode_word[3p+2:3p]`, and `out_point` carries the index of the point whose window completed.
- R10: Windows of different points fill independently, so interleaved samples of one point do not disturb another point's window.
- R11: A change in a point's mode field discards that point's partial window, and the next sample starts a new window under the new mode.
- R12: `out_valid` is high for exactly the one cycle after a window-completing sample is accepted, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_word | input | 12 | Four 3-bit mode fields, point p at bits [3p+2:3p] |
| smp_valid | input | 1 | Sample present this cycle |
| smp_point | input | 2 | Sensing point index of the sample |
| smp_data | input | 16 | Raw unsigned sample |
| out_valid | output | 1 | One-cycle strobe: a filtered value is present |
| out_point | output | 2 | Point index of the filtered value |
| out_value | output | 16 | Filtered value |

## Verification
Every result is due exactly one cycle after the clock edge that accepts the window's last sample, since the only register on the path is the lane's output register. The bench drives each sample on a falling edge and samples the outputs on the next falling edge. Each sample's response is therefore read in its own cycle. For every non-final sample the bench checks that no strobe appears, and for the final sample it checks the value and the point. For mode changes and interleaving, the bench reads the same one-cycle slot after each sample, so a stale or early window shows up as a strobe in the wrong slot.

// File: rtl/trim_filter_pkg.sv
package trim_filter_pkg;

    localparam int TF_SMP_W   = 16;
    localparam int TF_NPTS    = 4;
    localparam int TF_MODE_W  = 3;
    localparam int TF_MAX_WIN = 18;
    localparam int TF_CNT_W   = $clog2(TF_MAX_WIN + 1);
    localparam int TF_GUARD_W = $clog2(TF_MAX_WIN);

    typedef enum logic [TF_MODE_W-1:0] {
        TF_SINGLE = 3'b000,
        TF_PAIR   = 3'b001,
        TF_TRIM4  = 3'b010,
        TF_TRIM6  = 3'b011,
        TF_TRIM10 = 3'b100,
        TF_TRIM18 = 3'b101,
        TF_RSV6   = 3'b110,
        TF_RSV7   = 3'b111
    } tf_mode_e;

    // samples gathered per window
    function automatic int tf_win_len(input logic [TF_MODE_W-1:0] m);
        case (tf_mode_e'(m))
            TF_PAIR:   return 2;
            TF_TRIM4:  return 4;
            TF_TRIM6:  return 6;
            TF_TRIM10: return 10;
            TF_TRIM18: return 18;
            default:   return 1;
        endcase
    endfunction

    // log2 of the number of samples kept after trimming
    function automatic int tf_shift(input logic [TF_MODE_W-1:0] m);
        case (tf_mode_e'(m))
            TF_PAIR:   return 1;
            TF_TRIM4:  return 1;
            TF_TRIM6:  return 2;
            TF_TRIM10: return 3;
            TF_TRIM18: return 4;
            default:   return 0;
        endcase
    endfunction

    function automatic logic tf_trims(input logic [TF_MODE_W-1:0] m);
        case (tf_mode_e'(m))
            TF_TRIM4, TF_TRIM6, TF_TRIM10, TF_TRIM18: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tf_finalize.sv
module tf_finalize
    import trim_filter_pkg::*;
#(
    parameter int SMP_W = TF_SMP_W,
    parameter int ACC_W = SMP_W + TF_GUARD_W
) (
    input  logic [TF_MODE_W-1:0] mode,
    input  logic [ACC_W-1:0]     total,
    input  logic [SMP_W-1:0]     lo,
    input  logic [SMP_W-1:0]     hi,
    output logic [SMP_W-1:0]     result
);
    logic [ACC_W-1:0] kept;
    logic [ACC_W-1:0] scaled;

    always_comb begin
        if (tf_trims(mode))
            kept = total - ACC_W'(lo) - ACC_W'(hi);
        else
            kept = total;
        scaled = kept >> tf_shift(mode);
        result = scaled[SMP_W-1:0];
    end
endmodule

// File: rtl/tf_lane.sv
module tf_lane
    import trim_filter_pkg::*;
#(
    parameter int SMP_W = TF_SMP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TF_MODE_W-1:0] mode_fld,
    input  logic                 hit,
    input  logic [SMP_W-1:0]     x,
    output logic                 done,
    output logic [SMP_W-1:0]     res
);
    localparam int ACC_W = SMP_W + TF_GUARD_W;

    logic [TF_MODE_W-1:0] mode_q;
    logic [TF_CNT_W-1:0]  cnt_q, cnt_b, cnt_n;
    logic [ACC_W-1:0]     sum_q, sum_b, sum_n;
    logic [SMP_W-1:0]     mn_q, mx_q, mn_n, mx_n;
    logic                 restart, first, last;
    logic [SMP_W-1:0]     fin_res;

    always_comb begin
        restart = (mode_fld != mode_q);
        cnt_b   = restart ? '0 : cnt_q;
        sum_b   = restart ? '0 : sum_q;
        first   = (cnt_b == '0);
        mn_n    = (first || x < mn_q) ? x : mn_q;
        mx_n    = (first || x > mx_q) ? x : mx_q;
        sum_n   = sum_b + ACC_W'(x);
        cnt_n   = cnt_b + 1'b1;
        last    = (cnt_n == TF_CNT_W'(tf_win_len(mode_fld)));
    end

    tf_finalize #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_fin (
        .mode  (mode_fld),
        .total (sum_n),
        .lo    (mn_n),
        .hi    (mx_n),
        .result(fin_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cnt_q  <= '0;
            sum_q  <= '0;
            mn_q   <= '0;
            mx_q   <= '0;
            done   <= 1'b0;
            res    <= '0;
        end else begin
            mode_q <= mode_fld;
            done   <= hit && last;
            if (hit) begin
                mn_q <= mn_n;
                mx_q <= mx_n;
                if (last) begin
                    cnt_q <= '0;
                    sum_q <= '0;
                    res   <= fin_res;
                end else begin
                    cnt_q <= cnt_n;
                    sum_q <= sum_n;
                end
            end else begin
                cnt_q <= cnt_b;
                sum_q <= sum_b;
            end
        end
    end
endmodule

// File: rtl/trim_filter.sv
module trim_filter
    import trim_filter_pkg::*;
#(
    parameter int SMP_W = TF_SMP_W,
    parameter int NPTS  = TF_NPTS,
    localparam int PT_W = $clog2(NPTS),
    localparam int CW_W = TF_MODE_W * NPTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW_W-1:0]  mode_word,
    input  logic             smp_valid,
    input  logic [PT_W-1:0]  smp_point,
    input  logic [SMP_W-1:0] smp_data,
    output logic             out_valid,
    output logic [PT_W-1:0]  out_point,
    output logic [SMP_W-1:0] out_value
);
    logic [NPTS-1:0]  lane_done;
    logic [SMP_W-1:0] lane_res [NPTS];

    for (genvar p = 0; p < NPTS; p++) begin : g_lane
        tf_lane #(.SMP_W(SMP_W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .mode_fld(mode_word[TF_MODE_W*p +: TF_MODE_W]),
            .hit     (smp_valid && (smp_point == PT_W'(p))),
            .x       (smp_data),
            .done    (lane_done[p]),
            .res     (lane_res[p])
        );
    end

    // at most one lane completes per cycle: OR-merge
    always_comb begin
        out_valid = |lane_done;
        out_point = '0;
        out_value = '0;
        for (int p = 0; p < NPTS; p++) begin
            if (lane_done[p]) begin
                out_point = out_point | PT_W'(p);
                out_value = out_value | lane_res[p];
            end
        end
    end
endmodule

// File: rtl/trim_filter_chk.sv
module trim_filter_chk #(
    parameter int SMP_W = 16,
    parameter int NPTS  = 4,
    parameter int PT_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [3*NPTS-1:0] mode_word,
    input logic             smp_valid,
    input logic [PT_W-1:0]  smp_point,
    input logic [SMP_W-1:0] smp_data,
    input logic             out_valid,
    input logic [PT_W-1:0]  out_point,
    input logic [SMP_W-1:0] out_value,
    input logic [NPTS-1:0]  lane_done
);
    logic [2:0] cur_fld;
    logic       pass_mode;
    always_comb begin
        cur_fld   = mode_word[3*smp_point +: 3];
        pass_mode = (cur_fld == 3'b000) || (cur_fld == 3'b110) || (cur_fld == 3'b111);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R12
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(smp_valid));

    // R9
    point_tag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_point == $past(smp_point));

    // R2 R8
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        $past(smp_valid) && $past(pass_mode) |-> out_valid && out_value == $past(smp_data));

    // R10
    single_lane_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lane_done));
endmodule

bind trim_filter trim_filter_chk #(.SMP_W(SMP_W), .NPTS(NPTS), .PT_W(PT_W)) u_chk (
    .clk(clk), .rst(rst), .mode_word(mode_word), .smp_valid(smp_valid),
    .smp_point(smp_point), .smp_data(smp_data), .out_valid(out_valid),
    .out_point(out_point), .out_value(out_value), .lane_done(lane_done)
);

// File: tb/trim_filter_test.sv
`timescale 1ns/1ps
module trim_filter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mode_word = '0;
    logic        smp_valid = 1'b0;
    logic [1:0]  smp_point = '0;
    logic [15:0] smp_data = '0;
    logic        out_valid;
    logic [1:0]  out_point;
    logic [15:0] out_value;

    int errors = 0;
    int checks = 0;
    logic        obs_v;
    logic [1:0]  obs_p;
    logic [15:0] obs_d;
    logic [15:0] vals [18];
    logic [31:0] lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    trim_filter uut (
        .clk(clk), .rst(rst), .mode_word(mode_word), .smp_valid(smp_valid),
        .smp_point(smp_point), .smp_data(smp_data), .out_valid(out_valid),
        .out_point(out_point), .out_value(out_value)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[23:8];
    endfunction

    // drive one sample from a falling edge; observe its response slot
    task automatic send(input int pt, input logic [15:0] d);
        smp_valid = 1'b1;
        smp_point = 2'(pt);
        smp_data  = d;
        @(negedge clk);
        obs_v = out_valid;
        obs_p = out_point;
        obs_d = out_value;
        smp_valid = 1'b0;
    endtask

    task automatic set_mode(input int pt, input logic [2:0] m);
        mode_word[3*pt +: 3] = m;
        @(negedge clk);
    endtask

    function automatic int win_n(input logic [2:0] m);
        case (m)
            3'd1: return 2;  3'd2: return 4;  3'd3: return 6;
            3'd4: return 10; 3'd5: return 18; default: return 1;
        endcase
    endfunction

    // expected result from the requirement text: trimmed mean, floored
    function automatic logic [15:0] expect_val(input logic [2:0] m);
        int n, s, lo, hi, kept;
        n = win_n(m);
        s = 0; lo = 70000; hi = -1;
        for (int i = 0; i < n; i++) begin
            s += int'(vals[i]);
            if (int'(vals[i]) < lo) lo = int'(vals[i]);
            if (int'(vals[i]) > hi) hi = int'(vals[i]);
        end
        if (n >= 4) begin
            s = s - lo - hi;
            kept = n - 2;
        end else kept = n;
        return 16'(s / kept);
    endfunction

    task automatic run_window(input string req, input int pt, input logic [2:0] m);
        int n;
        n = win_n(m);
        for (int i = 0; i < n; i++) begin
            send(pt, vals[i]);
            if (i < n - 1) chk({req, " no early strobe"}, 32'(obs_v), 0);
        end
        chk({req, " strobe"}, 32'(obs_v), 1);
        chk({req, " point"}, 32'(obs_p), 32'(pt));
        chk({req, " value"}, 32'(obs_d), 32'(expect_val(m)));
    endtask

    task automatic t_reset();
        chk("R1 valid in reset", 32'(out_valid), 0);
        @(negedge clk); rst = 1'b0;
        chk("R1 valid after reset", 32'(out_valid), 0);
        @(negedge clk);
        chk("R12 idle", 32'(out_valid), 0);
    endtask

    task automatic t_pass();
        set_mode(0, 3'b000);
        send(0, 16'hBEEF);
        chk("R2 strobe", 32'(obs_v), 1);
        chk("R2 value", 32'(obs_d), 32'hBEEF);
        send(0, 16'h0000);
        chk("R2 zero", 32'(obs_d), 0);
        @(negedge clk);
        chk("R12 single cycle", 32'(out_valid), 0);
    endtask

    task automatic t_modes();
        for (int m = 1; m <= 5; m++) begin
            set_mode(1, 3'(m));
            for (int i = 0; i < 18; i++) vals[i] = rnd();
            case (m)
                1: run_window("R3", 1, 3'(m));
                2: run_window("R4", 1, 3'(m));
                3: run_window("R5", 1, 3'(m));
                4: run_window("R6", 1, 3'(m));
                default: run_window("R7", 1, 3'(m));
            endcase
        end
        // full-scale, no overflow
        for (int i = 0; i < 18; i++) vals[i] = 16'hFFFF;
        run_window("R7 fullscale", 1, 3'b101);
        // duplicated extremes: only one copy dropped
        for (int i = 0; i < 18; i++) vals[i] = (i < 3) ? 16'd0 : ((i < 6) ? 16'd1000 : 16'd500);
        run_window("R7 duplicates", 1, 3'b101);
        vals[0] = 16'd3; vals[1] = 16'd4;
        set_mode(1, 3'b001);
        run_window("R3 floor", 1, 3'b001);
    endtask

    task automatic t_reserved();
        set_mode(2, 3'b110);
        send(2, 16'h1357);
        chk("R8 code 110", 32'(obs_v ? obs_d : 16'h0), 32'h1357);
        set_mode(2, 3'b111);
        send(2, 16'h2468);
        chk("R8 code 111", 32'(obs_v ? obs_d : 16'h0), 32'h2468);
    endtask

    task automatic t_fields();
        mode_word = {3'b011, 3'b010, 3'b001, 3'b000};
        @(negedge clk);
        for (int i = 0; i < 18; i++) vals[i] = rnd();
        run_window("R9 point2 bits 8:6", 2, 3'b010);
        run_window("R9 point3 bits 11:9", 3, 3'b011);
    endtask

    task automatic t_interleave();
        logic [15:0] a [4];
        logic [15:0] b [2];
        a = '{16'd100, 16'd7, 16'd900, 16'd50};
        b = '{16'd10, 16'd21};
        mode_word = {3'b000, 3'b001, 3'b010, 3'b000};
        @(negedge clk);
        send(1, a[0]); chk("R10 p1 s0", 32'(obs_v), 0);
        send(2, b[0]); chk("R10 p2 s0", 32'(obs_v), 0);
        send(1, a[1]); chk("R10 p1 s1", 32'(obs_v), 0);
        send(1, a[2]); chk("R10 p1 s2", 32'(obs_v), 0);
        send(2, b[1]);
        chk("R10 p2 done", 32'(obs_v), 1);
        chk("R10 p2 point", 32'(obs_p), 2);
        chk("R10 p2 value", 32'(obs_d), 15);
        send(1, a[3]);
        chk("R10 p1 done", 32'(obs_v), 1);
        chk("R10 p1 value", 32'(obs_d), 75);
    endtask

    task automatic t_restart();
        set_mode(3, 3'b011);
        send(3, 16'd40000); send(3, 16'd40000); send(3, 16'd40000);
        chk("R11 partial", 32'(obs_v), 0);
        set_mode(3, 3'b001);
        send(3, 16'd8);
        chk("R11 restart first", 32'(obs_v), 0);
        send(3, 16'd12);
        chk("R11 restart strobe", 32'(obs_v), 1);
        chk("R11 restart value", 32'(obs_d), 10);
        // change and back with no samples still discards
        set_mode(3, 3'b001);
        send(3, 16'd500);
        set_mode(3, 3'b010);
        set_mode(3, 3'b001);
        send(3, 16'd2);
        chk("R11 toggled no strobe", 32'(obs_v), 0);
        send(3, 16'd4);
        chk("R11 toggled value", 32'(obs_d), 3);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        t_pass();
        t_modes();
        t_reserved();
        t_fields();
        t_interleave();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule